// File: doc/BRIEF.md
# DMA Destination Address Sequencer

This block holds and advances the destination address of a single DMA channel. Each completed transfer moves the address according to a two-bit update mode. The address can stay fixed, step up or step down, and the step is one for a byte transfer and two for a word transfer. When the destination is an external device served through the acknowledge handshake in single-address mode, the address is left alone whatever the mode says.

The block can also confine the address to a repeat area. The repeat area is a naturally aligned window of 2^RPT_LOG2 bytes, taken from the upper bits of the current address. When an update would carry the address out of the window, it wraps to the other end instead. If repeat stopping is armed, that overflow also stops the channel and raises a sticky repeat flag. The flag and the channel's interrupt enable together form the CPU interrupt request.

In block mode the stop is held back until the block-end strobe arrives. Software can re-enable the channel later, and the transfer then continues from the address at which it stopped.

Top module: `dma_dst_addr_seq`

## Requirements
- R1: The update mode `mode_i` is decoded as follows: 2'b00 and 2'b01 keep the address fixed, 2'b10 adds the step, and 2'b11 subtracts the step. The new address appears on the clock edge that samples `xfer_done_i`.
- R2: The step is 1 when `word_i`=0 (byte transfer) and 2 when `word_i`=1 (word transfer).
- R3: While `single_ack_i`=1, a transfer leaves the address unchanged in every mode.
- R4: Repeat stopping is armed when `rpt_area_en_i`=1, `rpt_irq_en_i`=1 and `blk_mode_i`=0. If an armed transfer overflows the window, the same clock edge sets `rpt_flag_o` to 1 and `ch_en_o` to 0.
- R5: While `rpt_area_en_i`=1, the address bits [RPT_LOG2-1:0] wrap modulo the window size and the upper bits stay the same, in both directions. While `rpt_area_en_i`=0, the whole address steps freely.
- R6: `irq_o` is 1 exactly when `rpt_flag_o`=1 and `irq_en_i`=1. The flag stays set until a `flag_clr_i` pulse clears it.
- R7: After a repeat stop, a `ch_en_set_i` pulse re-enables the channel. The next transfer steps on from the address that was held at the stop.
- R8: With `blk_mode_i`=1, a repeat overflow does not stop the channel at once. The stop and the flag take effect on the edge that samples `blk_end_i`.
- R9: While `rpt_area_en_i`=0, `rpt_irq_en_i` has no effect: an address that carries across a window boundary neither sets the flag nor stops the channel.
- R10: After reset the address is 0, the channel is disabled, and the flag and the interrupt request are 0. `load_i` copies `start_addr_i` into the address. `xfer_done_i` is ignored while `ch_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the start address |
| start_addr_i | input | ADDR_W | Programmed start address |
| xfer_done_i | input | 1 | One transfer completed |
| word_i | input | 1 | 1 = word transfer, 0 = byte transfer |
| mode_i | input | 2 | Address update mode |
| single_ack_i | input | 1 | Destination is an acknowledge-handshake device in single-address mode |
| rpt_area_en_i | input | 1 | Repeat area configured |
| rpt_irq_en_i | input | 1 | Stop and flag on repeat overflow |
| irq_en_i | input | 1 | Channel interrupt enable |
| blk_mode_i | input | 1 | Block transfer mode |
| blk_end_i | input | 1 | End of the current block |
| ch_en_set_i | input | 1 | Set the channel enable |
| flag_clr_i | input | 1 | Clear the repeat flag |
| addr_o | output | ADDR_W | Current destination address |
| ch_en_o | output | 1 | Channel enable state |
| rpt_flag_o | output | 1 | Repeat-overflow flag |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench drives the window edges in both directions: a word increment from offset 0xE, a byte increment from 0xF, and a byte decrement from 0x0. A design that carried into the upper bits, or that compared against the wrong edge, would leave the window or stop at the wrong transfer. It checks that the stop lands in the block-end cycle in block mode and not at the overflow, and that a re-enabled channel continues from the held address instead of a reloaded one. A design that failed here would stop early or lose its place. It also crosses a window boundary with the area disabled and stopping armed, and drives transfers while the channel is disabled, single-address mode is set, or the mode is fixed. In all of these cases a faulty design would move the address or raise the flag when it should not.

// File: rtl/dst_seq_pkg.sv
package dst_seq_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD0 = 2'b00,
    UPD_HOLD1 = 2'b01,
    UPD_INC   = 2'b10,
    UPD_DEC   = 2'b11
  } upd_mode_e;
endpackage

// File: rtl/dst_step_calc.sv
module dst_step_calc #(
  parameter int ADDR_W   = 24,
  parameter int RPT_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  input  logic              word_i,
  input  logic              single_ack_i,
  input  logic              area_en_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              wrap_o
);
  import dst_seq_pkg::*;
  localparam int OFF_W = RPT_LOG2 + 1;

  logic [OFF_W-1:0]  off_ext, off_inc, off_dec, step_off;
  logic [ADDR_W-1:0] step_full, full_inc, full_dec;
  upd_mode_e         mode;

  assign mode      = upd_mode_e'(mode_i);
  assign step_off  = word_i ? OFF_W'(2) : OFF_W'(1);
  assign step_full = word_i ? ADDR_W'(2) : ADDR_W'(1);
  assign off_ext   = {1'b0, addr_i[RPT_LOG2-1:0]};
  assign off_inc   = off_ext + step_off;
  assign off_dec   = off_ext - step_off;
  assign full_inc  = addr_i + step_full;
  assign full_dec  = addr_i - step_full;

  always_comb begin
    next_o = addr_i;
    wrap_o = 1'b0;
    if (!single_ack_i) begin
      unique case (mode)
        UPD_INC: begin
          if (area_en_i) begin
            next_o = {addr_i[ADDR_W-1:RPT_LOG2], off_inc[RPT_LOG2-1:0]};
            wrap_o = off_inc[RPT_LOG2];
          end else begin
            next_o = full_inc;
          end
        end
        UPD_DEC: begin
          if (area_en_i) begin
            next_o = {addr_i[ADDR_W-1:RPT_LOG2], off_dec[RPT_LOG2-1:0]};
            wrap_o = off_dec[RPT_LOG2];
          end else begin
            next_o = full_dec;
          end
        end
        default: begin
          next_o = addr_i;
          wrap_o = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dst_stop_ctrl.sv
module dst_stop_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic xfer_ok_i,
  input  logic wrap_i,
  input  logic area_en_i,
  input  logic rpt_irq_en_i,
  input  logic blk_mode_i,
  input  logic blk_end_i,
  input  logic set_en_i,
  input  logic flag_clr_i,
  output logic ch_en_o,
  output logic flag_o
);
  logic armed_hit, stop_now, pend_q;

  assign armed_hit = xfer_ok_i & wrap_i & area_en_i & rpt_irq_en_i;
  assign stop_now  = (armed_hit & ~blk_mode_i) |
                     (ch_en_o & blk_end_i & (pend_q | armed_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en_o <= 1'b0;
      flag_o  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (stop_now)
        ch_en_o <= 1'b0;
      else if (set_en_i)
        ch_en_o <= 1'b1;

      if (stop_now)
        flag_o <= 1'b1;
      else if (flag_clr_i)
        flag_o <= 1'b0;

      if (load_i || stop_now)
        pend_q <= 1'b0;
      else if (armed_hit && blk_mode_i)
        pend_q <= 1'b1;
    end
  end

  // R4
  armed_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_hit && !blk_mode_i) |=> (!ch_en_o && flag_o));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(flag_clr_i));

  // R7
  enable_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ch_en_o) |-> $past(set_en_i));

  // R8
  block_defer_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_en_o && blk_mode_i && !blk_end_i) |=> ch_en_o);
endmodule

// File: rtl/dma_dst_addr_seq.sv
module dma_dst_addr_seq #(
  parameter int ADDR_W   = 24,
  parameter int RPT_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              xfer_done_i,
  input  logic              word_i,
  input  logic [1:0]        mode_i,
  input  logic              single_ack_i,
  input  logic              rpt_area_en_i,
  input  logic              rpt_irq_en_i,
  input  logic              irq_en_i,
  input  logic              blk_mode_i,
  input  logic              blk_end_i,
  input  logic              ch_en_set_i,
  input  logic              flag_clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ch_en_o,
  output logic              rpt_flag_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] addr_q, addr_next;
  logic              wrap, xfer_ok;

  assign xfer_ok = xfer_done_i & ch_en_o;

  dst_step_calc #(.ADDR_W(ADDR_W), .RPT_LOG2(RPT_LOG2)) u_step (
    .addr_i       (addr_q),
    .mode_i       (mode_i),
    .word_i       (word_i),
    .single_ack_i (single_ack_i),
    .area_en_i    (rpt_area_en_i),
    .next_o       (addr_next),
    .wrap_o       (wrap)
  );

  dst_stop_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .xfer_ok_i    (xfer_ok),
    .wrap_i       (wrap),
    .area_en_i    (rpt_area_en_i),
    .rpt_irq_en_i (rpt_irq_en_i),
    .blk_mode_i   (blk_mode_i),
    .blk_end_i    (blk_end_i),
    .set_en_i     (ch_en_set_i),
    .flag_clr_i   (flag_clr_i),
    .ch_en_o      (ch_en_o),
    .flag_o       (rpt_flag_o)
  );

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (load_i)
      addr_q <= start_addr_i;
    else if (xfer_ok)
      addr_q <= addr_next;
  end

  assign addr_o = addr_q;
  assign irq_o  = rpt_flag_o & irq_en_i;

  // R10
  addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !(xfer_done_i && ch_en_o)) |=> $stable(addr_q));

  // R1
  fixed_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !mode_i[1]) |=> $stable(addr_q));

  // R3
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && single_ack_i) |=> $stable(addr_q));

  // R5
  window_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && rpt_area_en_i) |=> (addr_q[ADDR_W-1:RPT_LOG2] == $past(addr_q[ADDR_W-1:RPT_LOG2])));
endmodule

// File: tb/dma_dst_addr_seq_bench.sv
module dma_dst_addr_seq_bench;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 0, xfer_done_i = 0, word_i = 0, single_ack_i = 0;
  logic rpt_area_en_i = 0, rpt_irq_en_i = 0, irq_en_i = 0;
  logic blk_mode_i = 0, blk_end_i = 0, ch_en_set_i = 0, flag_clr_i = 0;
  logic [1:0] mode_i = 2'b00;
  logic [AW-1:0] start_addr_i = '0;
  logic [AW-1:0] addr_o;
  logic ch_en_o, rpt_flag_o, irq_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_dst_addr_seq #(.ADDR_W(AW), .RPT_LOG2(4)) u_dma_dst_addr_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .start_addr_i(start_addr_i),
    .xfer_done_i(xfer_done_i), .word_i(word_i), .mode_i(mode_i),
    .single_ack_i(single_ack_i), .rpt_area_en_i(rpt_area_en_i),
    .rpt_irq_en_i(rpt_irq_en_i), .irq_en_i(irq_en_i), .blk_mode_i(blk_mode_i),
    .blk_end_i(blk_end_i), .ch_en_set_i(ch_en_set_i), .flag_clr_i(flag_clr_i),
    .addr_o(addr_o), .ch_en_o(ch_en_o), .rpt_flag_o(rpt_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) xfer_done_i = 1;
      @(negedge clk) xfer_done_i = 0;
    end
  endtask

  task automatic load(input logic [AW-1:0] a);
    @(negedge clk) begin load_i = 1; start_addr_i = a; end
    @(negedge clk) load_i = 0;
  endtask

  task automatic enable();
    @(negedge clk) ch_en_set_i = 1;
    @(negedge clk) ch_en_set_i = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr_i = 1;
    @(negedge clk) flag_clr_i = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset addr", addr_o, 0);
    chk("R10 reset en", ch_en_o, 0);
    chk("R10 reset flag", rpt_flag_o, 0);
    chk("R10 reset irq", irq_o, 0);
  endtask

  task automatic t_disabled();
    load(24'h001230);
    chk("R10 load", addr_o, 24'h001230);
    mode_i = 2'b10;
    xfer(2);
    chk("R10 disabled ignores xfer", addr_o, 24'h001230);
  endtask

  task automatic t_step();
    enable();
    mode_i = 2'b10; word_i = 0;
    xfer(3);
    chk("R1 R2 byte inc", addr_o, 24'h001233);
    word_i = 1;
    xfer(2);
    chk("R2 word inc", addr_o, 24'h001237);
    load(24'h001230);
    mode_i = 2'b11;
    xfer(1);
    chk("R1 R5 word dec free", addr_o, 24'h00122E);
    word_i = 0;
    xfer(1);
    chk("R2 byte dec", addr_o, 24'h00122D);
  endtask

  task automatic t_fixed();
    mode_i = 2'b00; xfer(2);
    chk("R1 mode 00 fixed", addr_o, 24'h00122D);
    mode_i = 2'b01; xfer(2);
    chk("R1 mode 01 fixed", addr_o, 24'h00122D);
  endtask

  task automatic t_single();
    single_ack_i = 1;
    mode_i = 2'b10; xfer(1);
    chk("R3 single inc ignored", addr_o, 24'h00122D);
    mode_i = 2'b11; xfer(1);
    chk("R3 single dec ignored", addr_o, 24'h00122D);
    single_ack_i = 0;
  endtask

  task automatic t_wrap();
    rpt_area_en_i = 1; rpt_irq_en_i = 0;
    load(24'h00012E);
    mode_i = 2'b10; word_i = 1;
    xfer(1);
    chk("R5 inc wrap", addr_o, 24'h000120);
    chk("R5 no stop unarmed", ch_en_o, 1);
    chk("R5 no flag unarmed", rpt_flag_o, 0);
    mode_i = 2'b11; word_i = 0;
    xfer(1);
    chk("R5 dec wrap", addr_o, 24'h00012F);
  endtask

  task automatic t_stop();
    rpt_irq_en_i = 1; irq_en_i = 1;
    mode_i = 2'b10; word_i = 0;
    xfer(1);
    chk("R4 stop addr", addr_o, 24'h000120);
    chk("R4 stop en", ch_en_o, 0);
    chk("R4 flag", rpt_flag_o, 1);
    chk("R6 irq on", irq_o, 1);
    xfer(1);
    chk("R10 stopped ignores xfer", addr_o, 24'h000120);
    irq_en_i = 0; #1;
    chk("R6 irq masked", irq_o, 0);
    irq_en_i = 1;
    enable();
    chk("R7 re-enabled", ch_en_o, 1);
    chk("R6 flag sticky", rpt_flag_o, 1);
    xfer(1);
    chk("R7 resume addr", addr_o, 24'h000121);
    clear_flag();
    chk("R6 flag cleared", rpt_flag_o, 0);
    chk("R6 irq cleared", irq_o, 0);
  endtask

  task automatic t_block();
    blk_mode_i = 1;
    load(24'h00012F);
    xfer(1);
    chk("R8 no early stop", ch_en_o, 1);
    chk("R8 no early flag", rpt_flag_o, 0);
    xfer(1);
    chk("R8 continues", addr_o, 24'h000121);
    @(negedge clk) blk_end_i = 1;
    @(negedge clk) blk_end_i = 0;
    chk("R8 stop at block end", ch_en_o, 0);
    chk("R8 flag at block end", rpt_flag_o, 1);
    chk("R8 addr held", addr_o, 24'h000121);
    blk_mode_i = 0;
    clear_flag();
    enable();
  endtask

  task automatic t_no_area();
    rpt_area_en_i = 0; rpt_irq_en_i = 1;
    load(24'h0000FF);
    xfer(1);
    chk("R9 free carry", addr_o, 24'h000100);
    chk("R9 no stop", ch_en_o, 1);
    chk("R9 no flag", rpt_flag_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_step();
    t_fixed();
    t_single();
    t_wrap();
    t_stop();
    t_block();
    t_no_area();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule